// File: doc/BRIEF.md
# Command-byte serial register slave

This block is a slave on a three-wire serial port: an active-low select, a clock from the host and one shared data line. While the select is low, each frame carries an 8-bit command and then a 16-bit data word, both most significant bit first. Write commands store the data word in a small configuration register or load it into the turn counter. Read commands hand the data line over to the slave, which then shifts out a status word.

The status word is either the current angle or the turn count. The angle word carries the lock flag and the field-strength code with it. The counter word carries the stored-memory error flag. Both words end in an odd-parity bit.

The port is sampled in the system clock domain. The select, clock and data inputs pass through synchronizer stages, and their edges are detected there. This means the serial clock must run well below the system clock. At the pad, the data line is split into an input, an output value and an output enable.

Top module: `cmd_serial_slave`

## Requirements
- R1: After reset the output enable is low, the output value is 0, the hysteresis-disable output is 0, the offset output is 0 and neither pulse output is high.
- R2: A frame is 24 serial clocks. Bits are sampled on rising serial clock edges: first the 8 command bits, then the 16 data bits, each field MSB first.
- R3: Command 0x17 stores the data word once its last bit is sampled. Bit 14 drives the hysteresis-disable output and bits 13:8 drive the 6-bit offset output. Bits 7:0 are ignored.
- R4: Bit 15 of a 0x17 write is the reset request. A one-cycle reset pulse is issued only when this stored bit changes from 0 to 1. Writing it as 1 again gives no further pulse until it has been written back to 0.
- R5: Command 0x14 produces a one-cycle counter-load pulse when the last data bit is sampled, with data bits 8:0 presented as the load value.
- R6: Command 0x00 returns {angle[8:0], lock, field[4:0], parity}, from bit 15 down to bit 0.
- R7: Command 0x04 returns {turns[8:0], error flag, 5'b0, parity}, from bit 15 down to bit 0.
- R8: In both read words, bit 0 makes the total count of ones in bits 15:0 odd.
- R9: On a read, the output enable stays low through the command byte. It is still low between the 8th rising edge and the following falling edge. It rises on that falling edge with bit 15, and each later falling edge presents the next lower bit.
- R10: The read word is captured when the 8th command bit is sampled. Input changes later in the frame do not alter it.
- R11: Any other command code changes no stored state and pulses no output. The data line stays undriven, with output value 0.
- R12: Select high clears the bit counter and releases the data line. A write frame cut short by the select does not take effect, and the next frame starts again at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sck | input | 1 | Serial clock from the host |
| sio_in | input | 1 | Data line value seen at the pad |
| sio_out | output | 1 | Value driven onto the data line |
| sio_oe | output | 1 | Drive enable for the data line |
| angle | input | 9 | Current angle |
| lock | input | 1 | Angle tracking locked flag |
| field | input | 5 | Field-strength code |
| otp_err | input | 1 | Stored-memory error flag |
| turns | input | 9 | Current turn count |
| cfg_hyst_dis | output | 1 | Hysteresis disable setting |
| cfg_offset | output | 6 | Dynamic offset setting |
| soft_rst | output | 1 | One-cycle reset request pulse |
| cnt_load | output | 1 | One-cycle turn counter load pulse |
| cnt_load_val | output | 9 | Value to load into the turn counter |

## Verification
Reads are tried with angle, lock and field values that are all zeros, a mixed pattern, and all ones at the top of the range. These separate field placement, bit order and parity polarity, since the all-zero word returns only the parity bit. Config writes alternate the reset-request bit between set, set again and cleared, which tells an edge-triggered pulse apart from a level. Unknown codes, a frame cut short by the select, and an angle change in the middle of a frame show respectively that decoding is exact, that writes commit only on the final bit, and that the read word is captured when the command completes.

// File: rtl/cmd_serial_slave.sv
module cmd_serial_slave #(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 16,
  parameter int ANG_W  = 9,
  parameter int FLD_W  = 5,
  parameter int OFS_W  = 6,
  parameter int SYNC_N = 2,
  parameter logic [CMD_W-1:0] OP_WCFG  = 8'h17,
  parameter logic [CMD_W-1:0] OP_SETCN = 8'h14,
  parameter logic [CMD_W-1:0] OP_RDCN  = 8'h04,
  parameter logic [CMD_W-1:0] OP_RDANG = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             sio_in,
  output logic             sio_out,
  output logic             sio_oe,
  input  logic [ANG_W-1:0] angle,
  input  logic             lock,
  input  logic [FLD_W-1:0] field,
  input  logic             otp_err,
  input  logic [ANG_W-1:0] turns,
  output logic             cfg_hyst_dis,
  output logic [OFS_W-1:0] cfg_offset,
  output logic             soft_rst,
  output logic             cnt_load,
  output logic [ANG_W-1:0] cnt_load_val
);
  localparam int FRAME = CMD_W + DATA_W;
  localparam int CW    = $clog2(FRAME + 1);
  localparam int PAY_W = ANG_W + 1 + FLD_W;
  localparam int B_RST = DATA_W - 1;
  localparam int B_HYS = DATA_W - 2;
  localparam int B_OFS = DATA_W - 3;

  typedef enum logic [1:0] {K_NONE, K_READ, K_CFG, K_CNT} kind_t;

  logic [SYNC_N-1:0] cs_s, ck_s, di_s;
  logic              ck_q;
  logic              cs_hi, ck_now, di;
  logic              ck_rise, ck_fall;
  logic [CW-1:0]     bitcnt;
  logic [FRAME-1:0]  rx, rx_nx;
  logic [DATA_W-1:0] tx;
  kind_t             kind;
  logic              rst_req;
  logic [PAY_W-1:0]  ang_pay, cnt_pay;
  logic [DATA_W-1:0] ang_word, cnt_word;

  assign cs_hi   = cs_s[SYNC_N-1];
  assign ck_now  = ck_s[SYNC_N-1];
  assign di      = di_s[SYNC_N-1];
  assign ck_rise = ck_now & ~ck_q;
  assign ck_fall = ~ck_now & ck_q;
  assign rx_nx   = {rx[FRAME-2:0], di};

  assign ang_pay  = {angle, lock, field};
  assign cnt_pay  = {turns, otp_err, {FLD_W{1'b0}}};
  assign ang_word = DATA_W'({ang_pay, ~^ang_pay});
  assign cnt_word = DATA_W'({cnt_pay, ~^cnt_pay});

  assign sio_out = sio_oe & tx[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s <= '1;
      ck_s <= '0;
      di_s <= '0;
      ck_q <= 1'b0;
    end else begin
      cs_s <= {cs_s[SYNC_N-2:0], cs_n};
      ck_s <= {ck_s[SYNC_N-2:0], sck};
      di_s <= {di_s[SYNC_N-2:0], sio_in};
      ck_q <= ck_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt       <= '0;
      rx           <= '0;
      tx           <= '0;
      kind         <= K_NONE;
      sio_oe       <= 1'b0;
      rst_req      <= 1'b0;
      cfg_hyst_dis <= 1'b0;
      cfg_offset   <= '0;
      soft_rst     <= 1'b0;
      cnt_load     <= 1'b0;
      cnt_load_val <= '0;
    end else begin
      soft_rst <= 1'b0;
      cnt_load <= 1'b0;
      if (cs_hi) begin
        bitcnt <= '0;
        kind   <= K_NONE;
        sio_oe <= 1'b0;
      end else begin
        if (ck_rise && bitcnt < CW'(FRAME)) begin
          bitcnt <= bitcnt + 1'b1;
          rx     <= rx_nx;
          if (bitcnt == CW'(CMD_W - 1)) begin
            if (rx_nx[CMD_W-1:0] == OP_RDANG) begin
              tx <= ang_word; kind <= K_READ;
            end else if (rx_nx[CMD_W-1:0] == OP_RDCN) begin
              tx <= cnt_word; kind <= K_READ;
            end else if (rx_nx[CMD_W-1:0] == OP_WCFG) begin
              kind <= K_CFG;
            end else if (rx_nx[CMD_W-1:0] == OP_SETCN) begin
              kind <= K_CNT;
            end else begin
              kind <= K_NONE;
            end
          end
          if (bitcnt == CW'(FRAME - 1)) begin
            if (kind == K_CFG) begin
              rst_req      <= rx_nx[B_RST];
              soft_rst     <= rx_nx[B_RST] & ~rst_req;
              cfg_hyst_dis <= rx_nx[B_HYS];
              cfg_offset   <= rx_nx[B_OFS -: OFS_W];
            end else if (kind == K_CNT) begin
              cnt_load     <= 1'b1;
              cnt_load_val <= rx_nx[ANG_W-1:0];
            end
          end
        end
        if (ck_fall && kind == K_READ) begin
          if (bitcnt == CW'(CMD_W))
            sio_oe <= 1'b1;
          else if (bitcnt > CW'(CMD_W) && bitcnt < CW'(FRAME))
            tx <= {tx[DATA_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/cmd_serial_slave_chk.sv
module cmd_serial_slave_chk #(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 16,
  parameter int CW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_hi,
  input logic              oe,
  input logic [CW-1:0]     bitcnt,
  input logic [DATA_W-1:0] tx,
  input logic              soft_rst,
  input logic              cnt_load
);
  assert_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !oe);
  assert_turnaround_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> bitcnt == CW'(CMD_W));
  assert_odd_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> ^tx);
  assert_load_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> !cnt_load);
  assert_rst_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(soft_rst && cnt_load));
endmodule

bind cmd_serial_slave cmd_serial_slave_chk #(
  .CMD_W(CMD_W), .DATA_W(DATA_W), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .oe(sio_oe), .bitcnt(bitcnt),
  .tx(tx), .soft_rst(soft_rst), .cnt_load(cnt_load)
);

// File: tb/cmd_serial_slave_bench.sv
module cmd_serial_slave_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sio_in = 1'b0;
  logic sio_out, sio_oe;
  logic [8:0] angle = '0, turns = '0;
  logic lock = 1'b0, otp_err = 1'b0;
  logic [4:0] field = '0;
  logic cfg_hyst_dis, soft_rst, cnt_load;
  logic [5:0] cfg_offset;
  logic [8:0] cnt_load_val;

  int checks = 0, errors = 0;
  int rst_pulses = 0, load_pulses = 0;
  logic [8:0] last_load = '0;
  bit oe_seen, out_seen, poke_en;
  logic [8:0] poke_val;
  bit finished = 0;

  logic [15:0] exp_q[$], got_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  cmd_serial_slave u_cmd_serial_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sio_in(sio_in),
    .sio_out(sio_out), .sio_oe(sio_oe), .angle(angle), .lock(lock),
    .field(field), .otp_err(otp_err), .turns(turns),
    .cfg_hyst_dis(cfg_hyst_dis), .cfg_offset(cfg_offset),
    .soft_rst(soft_rst), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val));

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] mkword(input logic [8:0] hi, input logic mid, input logic [4:0] lo);
    mkword = {hi, mid, lo, ~^{hi, mid, lo}};
  endfunction

  initial forever begin
    @(posedge clk);
    if (soft_rst) rst_pulses++;
    if (cnt_load) begin load_pulses++; last_load = cnt_load_val; end
  end

  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [15:0] g, e;
      string t;
      g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(g == e, t, g, e);
    end
  end

  task automatic half();
    repeat (10) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] cmd, input logic [15:0] wd, input int nbits,
                       input bit is_read, output logic [15:0] rd);
    logic [23:0] bits;
    bit lo_oe[24], hi_oe[24];
    bits = {cmd, wd};
    rd = '0; oe_seen = 0; out_seen = 0;
    cs_n = 1'b0;
    half();
    for (int i = 0; i < nbits; i++) begin
      sio_in = bits[23-i];
      if (poke_en && i == 12) angle = poke_val;
      half();
      lo_oe[i] = sio_oe;
      if (sio_oe) oe_seen = 1;
      if (sio_out) out_seen = 1;
      if (i >= 8) rd[23-i] = sio_out;
      sck = 1'b1;
      half();
      hi_oe[i] = sio_oe;
      if (sio_oe) oe_seen = 1;
      sck = 1'b0;
    end
    half();
    cs_n = 1'b1;
    half();
    if (is_read) begin
      // R9: released during command and gap, driven for data bits
      chk(lo_oe[7] == 0 && hi_oe[7] == 0, "R9 gap after command", hi_oe[7], 0);
      chk(lo_oe[8] == 1 && lo_oe[23] == 1, "R9 driven in data phase", lo_oe[8], 1);
    end
    chk(sio_oe == 0, "R12 released after select high", sio_oe, 0);
  endtask

  task automatic do_read(input logic [7:0] cmd, input logic [15:0] exp, input string tag);
    logic [15:0] r;
    exp_q.push_back(exp); tag_q.push_back(tag);
    frame(cmd, 16'h0000, 24, 1, r);
    got_q.push_back(r);
  endtask

  task automatic do_write(input logic [7:0] cmd, input logic [15:0] wd, input int nbits);
    logic [15:0] r;
    frame(cmd, wd, nbits, 0, r);
  endtask

  initial begin
    repeat (6) @(negedge clk);
    // R1 reset state
    chk(sio_oe == 0 && sio_out == 0, "R1 line released", sio_oe, 0);
    chk(cfg_hyst_dis == 0 && cfg_offset == 0, "R1 config cleared", cfg_offset, 0);
    chk(soft_rst == 0 && cnt_load == 0, "R1 no pulses", soft_rst, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 R8 R2 angle reads with several patterns
    angle = 9'h0B5; lock = 1; field = 5'h13;
    do_read(8'h00, mkword(9'h0B5, 1, 5'h13), "R6 angle mixed");
    angle = 9'h000; lock = 0; field = 5'h00;
    do_read(8'h00, 16'h0001, "R8 angle zero parity");
    angle = 9'd359; lock = 1; field = 5'h1F;
    do_read(8'h00, mkword(9'd359, 1, 5'h1F), "R6 angle max");

    // R7 counter reads
    turns = 9'h1A5; otp_err = 1;
    do_read(8'h04, mkword(9'h1A5, 1, 5'h00), "R7 counter err");
    turns = 9'h000; otp_err = 0;
    do_read(8'h04, 16'h0001, "R7 counter zero");

    // R3 config write, low bits ignored
    do_write(8'h17, 16'h6AFF, 24);
    chk(cfg_hyst_dis == 1, "R3 hysteresis bit", cfg_hyst_dis, 1);
    chk(cfg_offset == 6'h2A, "R3 offset field", cfg_offset, 6'h2A);
    chk(rst_pulses == 0, "R3 no reset pulse", rst_pulses, 0);

    // R4 reset request edge behaviour
    do_write(8'h17, 16'h8000, 24);
    chk(rst_pulses == 1, "R4 first request pulses", rst_pulses, 1);
    chk(cfg_hyst_dis == 0 && cfg_offset == 0, "R3 config rewritten", cfg_offset, 0);
    do_write(8'h17, 16'h8000, 24);
    chk(rst_pulses == 1, "R4 repeated request silent", rst_pulses, 1);
    do_write(8'h17, 16'h0000, 24);
    do_write(8'h17, 16'h8000, 24);
    chk(rst_pulses == 2, "R4 request after clear", rst_pulses, 2);

    // R5 counter load
    do_write(8'h14, 16'hFF23, 24);
    chk(load_pulses == 1, "R5 load pulse count", load_pulses, 1);
    chk(last_load == 9'h123, "R5 load value", last_load, 9'h123);

    // R10 snapshot at end of command
    angle = 9'h055; lock = 0; field = 5'h0A;
    poke_en = 1; poke_val = 9'h1AA;
    do_read(8'h00, mkword(9'h055, 0, 5'h0A), "R10 snapshot angle");
    poke_en = 0;

    // R11 unknown codes
    do_write(8'h17, 16'h4500, 24);
    do_write(8'h55, 16'hFFFF, 24);
    chk(oe_seen == 0 && out_seen == 0, "R11 line undriven", oe_seen, 0);
    do_write(8'h01, 16'hC000, 24);
    chk(oe_seen == 0, "R11 near code undriven", oe_seen, 0);
    chk(cfg_hyst_dis == 1 && cfg_offset == 6'h05, "R11 config kept", cfg_offset, 6'h05);
    chk(rst_pulses == 2 && load_pulses == 1, "R11 no pulses", rst_pulses + load_pulses, 3);

    // R12 aborted write then clean restart
    do_write(8'h17, 16'hBF00, 20);
    chk(cfg_offset == 6'h05 && rst_pulses == 2, "R12 aborted write", cfg_offset, 6'h05);
    do_write(8'h14, 16'h0077, 12);
    chk(load_pulses == 1, "R12 aborted load", load_pulses, 1);
    angle = 9'h101; lock = 1; field = 5'h04;
    do_read(8'h00, mkword(9'h101, 1, 5'h04), "R12 R2 frame after abort");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all reads compared", exp_q.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R2 got=hang exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule